// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine for a 16-bit Frame Buffer

This block takes a stream of 32-bit commands and carries out two drawing jobs on a frame buffer that holds one 16-bit RGB565 pixel per two bytes: painting a rectangle with one colour, and copying a rectangle from one place to another. Most commands only set a parameter held inside the engine: the destination or source start byte address, the rectangle width and height (both coded as count minus one), or the fill colour. Two commands start work. While the engine works it holds busy and refuses further commands. When the last pixel has been written it gives a single-cycle done pulse.

The engine reaches memory through a single word port with a request, a write enable, a byte address and 16-bit write data. Read data comes back one cycle after the read request. The line width of the frame buffer, in pixels, is a configuration input that is sampled when an operation starts. Pixel (x, y) of a rectangle sits at the start address plus (y × line width + x) × 2.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, busy, done and mem_req are low and cmd_ready is high.
- R2: Bits 31:24 of a command hold its opcode. Opcode 0x0C loads the destination start byte address and opcode 0x0D loads the source start byte address, each from bits 23:0 with bit 0 forced to 0, so every memory address the engine drives is even.
- R3: Opcode 0x0E loads the width minus one and opcode 0x0F loads the height minus one, each from bits 9:0. Operand bits above bit 9 have no effect.
- R4: Opcode 0x0B loads the fill colour from bits 15:0. The colour is written unchanged as RGB565 (red in 15:11, green in 10:5, blue in 4:0). Operand bits 23:16 have no effect.
- R5: Opcode 0x23 fills the destination rectangle with the colour. It issues one write per cycle, left to right within a row and rows top to bottom, to address dst + (y × line width + x) × 2.
- R6: Opcode 0x21 copies the source rectangle to a destination rectangle of the same size, in the same raster order. Each pixel takes three cycles: a read of the source (its data returns in the next cycle), one cycle with no request, and then the write to the destination. Overlapping rectangles are not corrected, so a pixel written earlier is what a later read returns.
- R7: busy rises in the cycle after a start command is taken. It stays high for N+1 cycles for a fill of N pixels and for 3N+1 cycles for a copy. done is high for exactly one cycle, the first cycle with busy low, after the final write has been presented. mem_req is never high while busy is low.
- R8: cmd_ready is the inverse of busy. A command offered while busy is not taken and changes nothing.
- R9: A command with any other opcode is taken and discarded. It leaves every parameter unchanged and starts nothing.
- R10: The line width input is sampled when an operation starts. Changing it during an operation does not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_data | input | 32 | Command word: opcode in 31:24, operand below |
| cmd_ready | output | 1 | Engine can take a command this cycle |
| line_px | input | 11 | Frame buffer line width in pixels |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address, always even |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | An operation is executing |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The fill path is tried with a multi-row rectangle at an offset, with a single 1×1 pixel at an odd start address, and with a rectangle whose size commands carry junk in their upper operand bits. Together these separate errors in row stepping, in the count-minus-one limits, in forcing the address even and in masking the operand. The copy path is tried with disjoint rectangles and with a destination shifted one pixel right of its source on the same row. Only the overlapping case shows whether reads and writes stay in strict raster order, because the smear it produces depends on that order. A colour command offered while busy, followed by a change of the line width in the middle of an operation, checks that nothing is taken or re-sampled while the engine runs.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [7:0] OP_COLOUR  = 8'h0B;
  localparam logic [7:0] OP_DST     = 8'h0C;
  localparam logic [7:0] OP_SRC     = 8'h0D;
  localparam logic [7:0] OP_WIDTH   = 8'h0E;
  localparam logic [7:0] OP_HEIGHT  = 8'h0F;
  localparam logic [7:0] OP_COPY_GO = 8'h21;
  localparam logic [7:0] OP_FILL_GO = 8'h23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_FIN
  } exec_state_t;
endpackage

// File: rtl/blit_cmd_decode.sv
module blit_cmd_decode #(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [31:0]       cmd,
  output logic [ADDR_W-1:0] dst_base,
  output logic [ADDR_W-1:0] src_base,
  output logic [DIM_W-1:0]  w_m1,
  output logic [DIM_W-1:0]  h_m1,
  output logic [PIX_W-1:0]  colour,
  output logic              go_fill,
  output logic              go_copy
);
  import blit_pkg::*;

  logic [7:0] op;
  assign op = cmd[31:24];

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_base <= '0;
      src_base <= '0;
      w_m1     <= '0;
      h_m1     <= '0;
      colour   <= '0;
    end else if (accept) begin
      case (op)
        OP_DST:    dst_base <= {cmd[ADDR_W-1:1], 1'b0};
        OP_SRC:    src_base <= {cmd[ADDR_W-1:1], 1'b0};
        OP_WIDTH:  w_m1     <= cmd[DIM_W-1:0];
        OP_HEIGHT: h_m1     <= cmd[DIM_W-1:0];
        OP_COLOUR: colour   <= cmd[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    go_fill = accept && (op == OP_FILL_GO);
    go_copy = accept && (op == OP_COPY_GO);
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W  = 24,
  parameter int DIM_W   = 10,
  parameter int PITCH_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               step,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [DIM_W-1:0]   w_m1,
  input  logic [DIM_W-1:0]   h_m1,
  input  logic [PITCH_W-1:0] pitch,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [ADDR_W-1:0]  src_addr,
  output logic               last
);
  localparam int XPAD = ADDR_W - DIM_W - 1;
  localparam int PPAD = ADDR_W - PITCH_W - 1;

  logic [DIM_W-1:0]   x_q, y_q, wlim_q, hlim_q;
  logic [ADDR_W-1:0]  drow_q, srow_q, row_step_q;
  logic [ADDR_W-1:0]  x_bytes;
  logic               row_end;

  assign x_bytes = {{XPAD{1'b0}}, x_q, 1'b0};
  assign row_end = (x_q == wlim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q        <= '0;
      y_q        <= '0;
      wlim_q     <= '0;
      hlim_q     <= '0;
      drow_q     <= '0;
      srow_q     <= '0;
      row_step_q <= '0;
    end else if (start) begin
      x_q        <= '0;
      y_q        <= '0;
      wlim_q     <= w_m1;
      hlim_q     <= h_m1;
      drow_q     <= dst_base;
      srow_q     <= src_base;
      row_step_q <= {{PPAD{1'b0}}, pitch, 1'b0};
    end else if (step) begin
      if (row_end) begin
        x_q    <= '0;
        y_q    <= y_q + 1'b1;
        drow_q <= drow_q + row_step_q;
        srow_q <= srow_q + row_step_q;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  always_comb begin
    dst_addr = drow_q + x_bytes;
    src_addr = srow_q + x_bytes;
    last     = row_end && (y_q == hlim_q);
  end
endmodule

// File: rtl/blit_exec.sv
module blit_exec #(
  parameter int ADDR_W = 24,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_fill,
  input  logic              go_copy,
  input  logic [PIX_W-1:0]  colour,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              last,
  input  logic [PIX_W-1:0]  rdata,
  output logic              walk_start,
  output logic              walk_step,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [PIX_W-1:0]  wdata,
  output logic              busy,
  output logic              done
);
  import blit_pkg::*;

  exec_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          req <= 1'b0;
          we  <= 1'b0;
          if (go_fill)      state <= ST_FILL;
          else if (go_copy) state <= ST_RD;
        end
        ST_FILL: begin
          req   <= 1'b1;
          we    <= 1'b1;
          addr  <= dst_addr;
          wdata <= colour;
          state <= last ? ST_FIN : ST_FILL;
        end
        ST_RD: begin
          req   <= 1'b1;
          we    <= 1'b0;
          addr  <= src_addr;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          req   <= 1'b0;
          state <= ST_WR;
        end
        ST_WR: begin
          req   <= 1'b1;
          we    <= 1'b1;
          addr  <= dst_addr;
          wdata <= rdata;
          state <= last ? ST_FIN : ST_RD;
        end
        default: begin
          req   <= 1'b0;
          we    <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    walk_start = (state == ST_IDLE) && (go_fill || go_copy);
    walk_step  = (state == ST_FILL) || (state == ST_WR);
    busy       = (state != ST_IDLE);
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine #(
  parameter int ADDR_W  = 24,
  parameter int DIM_W   = 10,
  parameter int PITCH_W = 11,
  parameter int PIX_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [31:0]        cmd_data,
  output logic               cmd_ready,
  input  logic [PITCH_W-1:0] line_px,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic               busy,
  output logic               done
);
  logic              accept, go_fill, go_copy, walk_start, walk_step, last;
  logic [ADDR_W-1:0] dst_base, src_base, dst_addr, src_addr;
  logic [DIM_W-1:0]  w_m1, h_m1;
  logic [PIX_W-1:0]  colour;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  blit_cmd_decode #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W)) dec_i (
    .clk(clk), .rst(rst), .accept(accept), .cmd(cmd_data),
    .dst_base(dst_base), .src_base(src_base), .w_m1(w_m1), .h_m1(h_m1),
    .colour(colour), .go_fill(go_fill), .go_copy(go_copy)
  );

  blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) walk_i (
    .clk(clk), .rst(rst), .start(walk_start), .step(walk_step),
    .dst_base(dst_base), .src_base(src_base), .w_m1(w_m1), .h_m1(h_m1),
    .pitch(line_px), .dst_addr(dst_addr), .src_addr(src_addr), .last(last)
  );

  blit_exec #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) exec_i (
    .clk(clk), .rst(rst), .go_fill(go_fill), .go_copy(go_copy),
    .colour(colour), .dst_addr(dst_addr), .src_addr(src_addr), .last(last),
    .rdata(mem_rdata), .walk_start(walk_start), .walk_step(walk_step),
    .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/rect_blit_checker.sv
module rect_blit_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_req_needs_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_even_address_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  assert_read_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_req);

  assert_start_taken_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));
endmodule

bind rect_blit_engine rect_blit_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/rect_blit_engine_tb_top.sv
`timescale 1ns/1ps
module rect_blit_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready;
  logic [10:0] line_px = 11'd32;
  logic        mem_req, mem_we, busy, done;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] mem     [0:4095];
  logic [15:0] ref_mem [0:4095];
  logic [23:0] exp_addr[$];
  logic [15:0] exp_data[$];

  always #2.5 clk = ~clk;

  rect_blit_engine dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .line_px(line_px), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  // memory model: read data valid in the cycle after the request
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 16'(i * 7 + 3);
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[12:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[12:1]];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: every write is compared with the next expected item
  always @(negedge clk) begin
    if (!rst && mem_req && mem_we) begin
      if (exp_addr.size() == 0) begin
        check(0, "R5/R6 unexpected write", int'(mem_addr), 0);
      end else begin
        logic [23:0] ea;
        logic [15:0] ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        check(mem_addr == ea, "R5/R6 write address", int'(mem_addr), int'(ea));
        check(mem_wdata == ed, "R5/R6 write data", int'(mem_wdata), int'(ed));
      end
    end
  end

  task automatic push_fill(input int base, input int w, input int h, input int pitch,
                           input logic [15:0] col);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int a;
        a = base + (y * pitch + x) * 2;
        exp_addr.push_back(24'(a));
        exp_data.push_back(col);
        ref_mem[a / 2] = col;
      end
  endtask

  task automatic push_copy(input int dbase, input int sbase, input int w, input int h,
                           input int pitch);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int da, sa;
        da = dbase + (y * pitch + x) * 2;
        sa = sbase + (y * pitch + x) * 2;
        ref_mem[da / 2] = ref_mem[sa / 2];
        exp_addr.push_back(24'(da));
        exp_data.push_back(ref_mem[da / 2]);
      end
  endtask

  task automatic send(input logic [31:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // called at negedge number 'start' after the start command was taken
  task automatic wait_done(input int start, input int expc, input string tag);
    int cnt;
    cnt = start;
    if (start == 1) check(busy == 1'b1, {tag, " R7 busy after start"}, busy, 1);
    while (done !== 1'b1 && cnt < 100000) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == expc, {tag, " R7 done timing"}, cnt, expc);
    check(busy == 1'b0 && cmd_ready == 1'b1, {tag, " R7/R8 idle at done"}, busy, 0);
    check(exp_addr.size() == 0, {tag, " R5/R6 all writes seen"}, exp_addr.size(), 0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) ref_mem[i] = 16'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset values
    check(busy == 0 && done == 0 && mem_req == 0 && cmd_ready == 1,
          "R1 reset state", {busy, done, mem_req, cmd_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);

    // R5 R4: 4x3 fill at (2,1), magenta RGB565
    send(32'h0B00F81F);
    send(32'h0C000044);
    send(32'h0E000003);
    send(32'h0F000002);
    push_fill(32'h44, 4, 3, 32, 16'hF81F);
    send(32'h23000000);
    wait_done(1, 14, "R5 fill 4x3");

    // R2 odd address forced even, 1x1 boundary; R4 upper colour bits ignored
    send(32'h0C000201);
    send(32'h0E000000);
    send(32'h0F000000);
    send(32'h0BAB07E0);
    push_fill(32'h200, 1, 1, 32, 16'h07E0);
    send(32'h23000000);
    wait_done(1, 3, "R2 R4 fill 1x1");

    // R6 disjoint copy 3x2
    send(32'h0D000780);
    send(32'h0C000A0A);
    send(32'h0E000002);
    send(32'h0F000001);
    push_copy(32'hA0A, 32'h780, 3, 2, 32);
    send(32'h21000000);
    wait_done(1, 20, "R6 copy 3x2");

    // R6 overlapping copy, destination one pixel right of source
    send(32'h0D000280);
    send(32'h0C000282);
    send(32'h0E000003);
    send(32'h0F000000);
    push_copy(32'h282, 32'h280, 4, 1, 32);
    send(32'h21000000);
    wait_done(1, 14, "R6 overlap copy");

    // R3 upper size bits ignored; R9 unknown opcodes have no effect
    send(32'h0C000C94);
    send(32'h0E00FC02);
    send(32'h0FFFFC01);
    send(32'h5A123456);
    check(busy == 1'b0, "R9 unknown opcode starts nothing", busy, 0);
    send(32'h24000000);
    check(busy == 1'b0, "R9 other go opcode ignored", busy, 0);
    push_fill(32'hC94, 3, 2, 32, 16'h07E0);
    send(32'h23000000);
    wait_done(1, 8, "R3 R9 fill 3x2");

    // R8 command while busy is refused; R10 line width sampled at start
    send(32'h0B00001F);
    send(32'h0C000DC0);
    send(32'h0E000001);
    send(32'h0F000001);
    push_fill(32'hDC0, 2, 2, 32, 16'h001F);
    send(32'h23000000);
    line_px   = 11'd16;
    cmd_valid = 1'b1;
    cmd_data  = 32'h0B00FFFF;
    check(cmd_ready == 1'b0, "R8 ready low while busy", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(2, 6, "R10 fill with old width");
    push_fill(32'hDC0, 2, 2, 16, 16'h001F);
    send(32'h23000000);
    wait_done(1, 6, "R8 colour kept, new width");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule